// File: doc/BRIEF.md
# Dual-Path Masked Interrupt Aggregator

This block gathers a vector of level-sensitive interrupt request lines into two processor-facing requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Each request has its own enable mask. A request output is high while at least one source that is both active and enabled on that path is present. A small set of fixed source positions also takes the request lines of a four-channel timer unit.

Software sees two views per path. The raw view shows the current source levels without masking. The masked view shows those levels ANDed with that path's enable mask. Enable masks are never written directly. A write to a path's enable-set register turns on the bits that are 1 in the data. A write to its enable-clear register turns off the bits that are 1 in the data. Either way, single bits change with no read-modify-write.

Register reads are combinational in the cycle the address is presented. Writes take effect at the next clock edge. Both request outputs are registered. Each output is computed from the mask value that the same edge loads, so a mask write is reflected one edge after the write.

Top module: `irq_aggregator`

## Requirements
- R1: The raw view (address 0 for the normal path, address 4 for the fast path) returns the current source levels in the same cycle, with bit i equal to `src_i[i]`.
- R2: Timer line k (`tmr_i[k]`) is ORed into source bit TMR_LSB+k. TMR_LSB defaults to 8, so the timers occupy bits 8 to 11.
- R3: The masked view (address 1 for the normal path, address 5 for the fast path) returns the raw levels ANDed with that path's enable mask.
- R4: A write to enable-set (address 2 for the normal path, address 6 for the fast path) ORs the write data into that path's enable mask.
- R5: A write to enable-clear (address 3 for the normal path, address 7 for the fast path) clears every enable bit where the write data holds a 1.
- R6: After each clock edge, a request output equals the OR of (the source levels before that edge AND the enable mask loaded at that edge). Source changes and mask changes therefore show at the outputs one edge later.
- R7: Mask writes to one path leave the other path's mask and request output unchanged.
- R8: Address bit 2 selects the path and bits 1:0 select the register. A write to a raw or masked view is illegal: it raises `bus_err` in that cycle and changes no mask. A read of an enable-set or enable-clear register also raises `bus_err` and returns 0.
- R9: Reset clears both enable masks and drives both request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| tmr_i | input | NUM_TMR | Timer channel requests, merged at TMR_LSB |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address: bit 2 selects the path, bits 1:0 select the register |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data, combinational |
| bus_err | output | 1 | Illegal access flag, combinational |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume that a bus access lasts one cycle with stable address and data while `bus_sel` is high. They also assume that reset is applied synchronously at time zero. The bench drives every input on the falling edge and holds it across exactly one rising edge, so each access occupies a single cycle. It sweeps every source bit through both paths and every timer channel. Source levels change only between accesses, so a source change and a mask change never fall on the same edge unless a check intends it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        REG_RAW    = 2'd0,
        REG_MASKED = 2'd1,
        REG_SET    = 2'd2,
        REG_CLR    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PATH_IRQ = 1'b0,
        PATH_FIQ = 1'b1
    } path_e;

    localparam int NUM_PATHS = 2;

    typedef struct packed {
        logic     path;
        reg_sel_e sel;
    } reg_addr_t;

    function automatic logic [31:0] mask_next32(
        input logic [31:0] cur,
        input logic [31:0] data,
        input logic        do_set,
        input logic        do_clr
    );
        logic [31:0] r;
        r = cur;
        if (do_set) r = r | data;
        if (do_clr) r = r & ~data;
        return r;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
(
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [2:0]           bus_addr,
    output logic [NUM_PATHS-1:0] set_we,
    output logic [NUM_PATHS-1:0] clr_we,
    output logic                 rd_path,
    output reg_sel_e             rd_reg,
    output logic                 rd_en,
    output logic                 err
);
    reg_addr_t ra;
    logic      status_reg;

    always_comb begin
        ra         = reg_addr_t'(bus_addr);
        status_reg = (ra.sel == REG_RAW) || (ra.sel == REG_MASKED);
        set_we     = '0;
        clr_we     = '0;
        if (bus_sel && bus_we) begin
            set_we[ra.path] = (ra.sel == REG_SET);
            clr_we[ra.path] = (ra.sel == REG_CLR);
        end
        rd_path = ra.path;
        rd_reg  = ra.sel;
        rd_en   = bus_sel && !bus_we && status_reg;
        err     = bus_sel && (bus_we ? status_reg : !status_reg);
    end
endmodule

// File: rtl/irq_mask_path.sv
module irq_mask_path
    import irq_agg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en,
    output logic [W-1:0] masked,
    output logic         req_q
);
    logic [W-1:0] en_q;
    logic [W-1:0] en_nxt;

    always_comb begin
        en_nxt = en_q;
        if (set_we) en_nxt = en_nxt | wdata;
        if (clr_we) en_nxt = en_nxt & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            req_q <= 1'b0;
        end else begin
            en_q  <= en_nxt;
            req_q <= |(raw & en_nxt);
        end
    end

    assign en     = en_q;
    assign masked = raw & en_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_TMR = 4,
    parameter int TMR_LSB = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_TMR-1:0] tmr_i,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [2:0]         bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               bus_err,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int TMR_MSB = TMR_LSB + NUM_TMR - 1;

    logic [NUM_SRC-1:0]   raw;
    logic [NUM_PATHS-1:0] set_we;
    logic [NUM_PATHS-1:0] clr_we;
    logic                 rd_path;
    reg_sel_e             rd_reg;
    logic                 rd_en;
    logic [NUM_SRC-1:0]   en_arr     [NUM_PATHS];
    logic [NUM_SRC-1:0]   masked_arr [NUM_PATHS];
    logic [NUM_PATHS-1:0] req;
    logic [NUM_SRC-1:0]   en_irq;
    logic [NUM_SRC-1:0]   en_fiq;

    always_comb begin
        raw = src_i;
        for (int k = 0; k < NUM_TMR; k++) begin
            raw[TMR_LSB + k] = src_i[TMR_LSB + k] | tmr_i[k];
        end
    end

    irq_reg_decode u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .set_we  (set_we),
        .clr_we  (clr_we),
        .rd_path (rd_path),
        .rd_reg  (rd_reg),
        .rd_en   (rd_en),
        .err     (bus_err)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        irq_mask_path #(.W(NUM_SRC)) u_path (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw),
            .set_we(set_we[p]),
            .clr_we(clr_we[p]),
            .wdata (bus_wdata),
            .en    (en_arr[p]),
            .masked(masked_arr[p]),
            .req_q (req[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            bus_rdata = (rd_reg == REG_RAW) ? raw : masked_arr[rd_path];
        end
    end

    assign en_irq = en_arr[PATH_IRQ];
    assign en_fiq = en_arr[PATH_FIQ];
    assign irq_o  = req[PATH_IRQ];
    assign fiq_o  = req[PATH_FIQ];

    if (TMR_MSB >= NUM_SRC) begin : g_bad_cfg
        initial $error("timer field exceeds source width");
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [2:0]         bus_addr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               bus_err,
    input logic [NUM_SRC-1:0] raw,
    input logic [NUM_SRC-1:0] en_irq,
    input logic [NUM_SRC-1:0] en_fiq,
    input logic               irq_o,
    input logic               fiq_o
);
    p_mask_rd_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == 3'd1) |-> bus_rdata == (raw & en_irq));

    p_set_irq_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == 3'd2) |=> (en_irq & $past(bus_wdata)) == $past(bus_wdata));

    p_set_fiq_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == 3'd6) |=> (en_fiq & $past(bus_wdata)) == $past(bus_wdata));

    p_clr_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == 3'd3) |=> (en_irq & $past(bus_wdata)) == '0);

    p_clr_fiq_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == 3'd7) |=> (en_fiq & $past(bus_wdata)) == '0);

    p_irq_out_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_o == |($past(raw) & en_irq));

    p_fiq_out_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> fiq_o == |($past(raw) & en_fiq));

    p_path_isolation_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && !bus_addr[2]) |=> $stable(en_fiq));

    p_no_mask_write_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_we && bus_addr[1]) |=> ($stable(en_irq) && $stable(en_fiq)));

    p_status_write_err_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && !bus_addr[1]) |-> bus_err);

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (en_irq == '0 && en_fiq == '0 && !irq_o && !fiq_o));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .raw      (raw),
    .en_irq   (en_irq),
    .en_fiq   (en_fiq),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    localparam int NS = 32;
    localparam int NT = 4;
    localparam int TL = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_i = '0;
    logic [NT-1:0] tmr_i = '0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [NS-1:0] bus_wdata = '0;
    logic [NS-1:0] bus_rdata;
    logic          bus_err;
    logic          irq_o;
    logic          fiq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    irq_aggregator #(.NUM_SRC(NS), .NUM_TMR(NT), .TMR_LSB(TL)) u_dut (
        .clk(clk), .rst(rst), .src_i(src_i), .tmr_i(tmr_i),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NS-1:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1 e = bus_err;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NS-1:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata; e = bus_err;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [NS-1:0] d;
        logic e;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R9 irq after reset", {31'b0, irq_o}, 0);
        chk("R9 fiq after reset", {31'b0, fiq_o}, 0);
        src_i = '1;
        rd(3'd1, d, e); chk("R9 irq mask zero", d, 0);
        rd(3'd5, d, e); chk("R9 fiq mask zero", d, 0);
        src_i = '0;

        for (int i = 0; i < NS; i++) begin
            logic [NS-1:0] b;
            b = NS'(1) << i;
            src_i = b;
            rd(3'd0, d, e); chk("R1 irq raw", d, b);
            rd(3'd4, d, e); chk("R1 fiq raw", d, b);
            wr(3'd2, b, e);
            chk("R4/R6 irq on", {31'b0, irq_o}, 1);
            chk("R7 fiq idle", {31'b0, fiq_o}, 0);
            rd(3'd1, d, e); chk("R3 irq masked", d, b);
            rd(3'd5, d, e); chk("R3 R7 fiq masked", d, 0);
            wr(3'd3, b, e);
            chk("R5 irq off", {31'b0, irq_o}, 0);
            wr(3'd6, b, e);
            chk("R4 fiq on", {31'b0, fiq_o}, 1);
            chk("R7 irq idle", {31'b0, irq_o}, 0);
            wr(3'd7, b, e);
            chk("R5 fiq off", {31'b0, fiq_o}, 0);
        end

        src_i = '1;
        wr(3'd2, 32'h0000_00F0, e);
        wr(3'd2, 32'h0000_0F00, e);
        rd(3'd1, d, e); chk("R4 set accumulates", d, 32'h0000_0FF0);
        wr(3'd3, 32'h0000_0F0F, e);
        rd(3'd1, d, e); chk("R5 clear selective", d, 32'h0000_00F0);

        wr(3'd0, '1, e); chk("R8 raw write err", {31'b0, e}, 1);
        wr(3'd5, '1, e); chk("R8 masked write err", {31'b0, e}, 1);
        rd(3'd1, d, e); chk("R8 irq mask kept", d, 32'h0000_00F0);
        rd(3'd5, d, e); chk("R8 fiq mask kept", d, 0);
        rd(3'd2, d, e);
        chk("R8 set read err", {31'b0, e}, 1);
        chk("R8 set read zero", d, 0);
        rd(3'd7, d, e); chk("R8 clr read err", {31'b0, e}, 1);
        rd(3'd1, d, e); chk("R8 legal read no err", {31'b0, e}, 0);

        @(negedge clk); src_i = 32'h0000_0010;
        @(negedge clk); chk("R6 source on", {31'b0, irq_o}, 1);
        src_i = 32'h0000_0001;
        @(negedge clk); chk("R6 masked source", {31'b0, irq_o}, 0);

        wr(3'd3, '1, e);
        src_i = '0;
        for (int t = 0; t < NT; t++) begin
            tmr_i = NT'(1) << t;
            rd(3'd0, d, e); chk("R2 timer raw", d, NS'(1) << (TL + t));
        end
        tmr_i = 4'b0100;
        wr(3'd6, NS'(1) << (TL + 2), e);
        chk("R2 timer fiq", {31'b0, fiq_o}, 1);
        tmr_i = '0;
        @(negedge clk);
        chk("R2 R6 timer drop", {31'b0, fiq_o}, 0);

        finish_run();
    end
endmodule